// File: doc/BRIEF.md
# Byte FIFO Pair with Threshold Interrupts

This block sits between a register bus and the shift engine of a serial controller. It holds two byte queues of 64 entries each: a transmit queue that software fills through a data register and the shift engine drains, and a receive queue that the shift engine fills and software drains through a second data register. A status word reports how many bytes each queue holds.

Three interrupt causes are tracked. The receive queue raises one when it is three quarters full. The transmit queue raises one when it is three quarters empty. The shift engine raises one with a single-cycle pulse when a transfer completes. Each cause latches into a status bit whether or not it is enabled. Software clears a bit by writing a one to it, and a threshold bit comes straight back while its condition still holds. Software should therefore service the queue before clearing the bit. The interrupt line is the OR of the enabled status bits. Each queue can also be emptied by a self-clearing flush bit in the control register.

The register bus is single-cycle: a write takes effect at the clock edge that samples it, and read data appears on `bus_rdata` one cycle after the read strobe. Register selects on `bus_addr`: 0 receive data (a read pops), 1 transmit data (a write pushes), 2 control, 3 interrupt enable, 4 interrupt status, 5 queue occupancy.

Top module: `dual_fifo_irq`

## Requirements
- R1: Each queue holds 64 bytes. A push to a full queue is dropped and its occupancy stays at 64. `eng_rx_full` is 1 while the receive queue holds 64 bytes.
- R2: Bytes leave each queue in the order they entered it. Transmit bytes are pushed by bus writes to select 1 and popped by the engine. Receive bytes are pushed by the engine and popped by bus reads of select 0.
- R3: A read of select 5 returns the receive occupancy in bits 6:0 and the transmit occupancy in bits 22:16. All other bits read 0.
- R4: A pop from an empty queue is ignored and leaves the occupancy at 0. A bus read of select 0 on an empty receive queue returns 0. `eng_tx_data` reads 0 while the transmit queue is empty.
- R5: Status bit 4 (receive high) is set on the cycle after the receive occupancy is 48 or more.
- R6: Status bit 12 (transmit low) is set on the cycle after the transmit occupancy is 16 or less.
- R7: Status bit 16 (transfer complete) is set on the cycle after an `eng_done` pulse.
- R8: Writing select 4 clears each status bit written as 1, unless that bit's cause is present in the same cycle, in which case the bit stays set. Bits written as 0 are unchanged. Writing all ones clears every bit whose cause is absent.
- R9: Select 3 holds enable bits at the same positions as the status bits (4, 12, 16) and reads back only those bits. `irq` is 1 exactly when some status bit and its enable bit are both 1.
- R10: Writing 1 to control bit 8 flushes the transmit queue, and writing 1 to control bit 9 flushes the receive queue. The flush takes effect one cycle after the write. The control bit reads 1 for that one cycle and then clears itself, and the flushed queue's occupancy becomes 0.
- R11: `eng_tx_data` shows the oldest transmit byte. `eng_tx_pop` advances it. `eng_tx_empty` is 1 while the transmit queue holds no bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register select |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, valid one cycle after the read strobe |
| eng_tx_pop | input | 1 | Shift engine takes the oldest transmit byte |
| eng_tx_data | output | 8 | Oldest transmit byte, 0 when empty |
| eng_tx_empty | output | 1 | Transmit queue holds no bytes |
| eng_rx_push | input | 1 | Shift engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_rx_full | output | 1 | Receive queue holds 64 bytes |
| eng_done | input | 1 | Single-cycle transfer-complete pulse |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `rst` is held for at least one edge before any strobe. They also assume that every strobe and data input is a known value at each sampled edge. They do not assume that the engine respects `eng_tx_empty` or `eng_rx_full`: the dropped-push and ignored-pop properties cover exactly those misuses. The stimulus changes every input only on the falling clock edge and issues at most one bus access per cycle. It deliberately overfills both queues and pops from empty ones.

// File: rtl/dfq_pkg.sv
package dfq_pkg;

    localparam int unsigned DATA_W      = 8;
    localparam int unsigned WORD_W      = 32;
    localparam int unsigned ADDR_W      = 3;

    // bit positions shared by the enable and status words
    localparam int unsigned BIT_RX_HIGH   = 4;
    localparam int unsigned BIT_TX_LOW    = 12;
    localparam int unsigned BIT_XFER_DONE = 16;

    // control word flush bits
    localparam int unsigned BIT_TX_FLUSH  = 8;
    localparam int unsigned BIT_RX_FLUSH  = 9;

    // occupancy word fields
    localparam int unsigned FST_RX_LSB    = 0;
    localparam int unsigned FST_TX_LSB    = 16;
    localparam int unsigned FST_FIELD_W   = 7;

    typedef enum logic [ADDR_W-1:0] {
        SEL_RXD   = 3'd0,
        SEL_TXD   = 3'd1,
        SEL_CTRL  = 3'd2,
        SEL_IEN   = 3'd3,
        SEL_ISTAT = 3'd4,
        SEL_FSTAT = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic xfer_done;
        logic tx_low;
        logic rx_high;
    } irq_vec_t;

    typedef struct packed {
        logic              wr;
        logic              rd;
        reg_sel_e          sel;
        logic [WORD_W-1:0] wdata;
    } bus_cmd_t;

    function automatic irq_vec_t word_to_irq(input logic [WORD_W-1:0] w);
        irq_vec_t v;
        v.rx_high   = w[BIT_RX_HIGH];
        v.tx_low    = w[BIT_TX_LOW];
        v.xfer_done = w[BIT_XFER_DONE];
        return v;
    endfunction

    function automatic logic [WORD_W-1:0] irq_to_word(input irq_vec_t v);
        logic [WORD_W-1:0] w;
        w                = '0;
        w[BIT_RX_HIGH]   = v.rx_high;
        w[BIT_TX_LOW]    = v.tx_low;
        w[BIT_XFER_DONE] = v.xfer_done;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] pack_fstat(
        input logic [FST_FIELD_W-1:0] rx_cnt,
        input logic [FST_FIELD_W-1:0] tx_cnt
    );
        logic [WORD_W-1:0] w;
        w                                  = '0;
        w[FST_RX_LSB +: FST_FIELD_W]       = rx_cnt;
        w[FST_TX_LSB +: FST_FIELD_W]       = tx_cnt;
        return w;
    endfunction

endpackage

// File: rtl/dfq_byte_fifo.sv
module dfq_byte_fifo #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned WIDTH = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     flush,
    input  logic                     push,
    input  logic [WIDTH-1:0]         push_data,
    input  logic                     pop,
    output logic [WIDTH-1:0]         head,
    output logic [$clog2(DEPTH):0]   count,
    output logic                     full,
    output logic                     empty
);

    localparam int unsigned PTR_W = $clog2(DEPTH);
    localparam int unsigned CNT_W = PTR_W + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             do_push;
    logic             do_pop;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1)) begin
            return '0;
        end
        return p + PTR_W'(1);
    endfunction

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign head    = empty ? '0 : mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= step(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= step(rd_ptr);
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // R1: occupancy never passes the depth
    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    // R1: a push into a full queue changes nothing
    assert_full_push_dropped_R1: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop && !flush) |=> (count == CNT_W'(DEPTH)));

    // R4: a pop from an empty queue changes nothing
    assert_empty_pop_ignored_R4: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push && !flush) |=> (count == '0));

    // R10: a flush leaves the queue empty
    assert_flush_empties_R10: assert property (@(posedge clk) disable iff (rst)
        flush |=> empty);

endmodule

// File: rtl/dfq_irq_unit.sv
module dfq_irq_unit
    import dfq_pkg::*;
#(
    parameter int unsigned CNT_W   = 7,
    parameter int unsigned RX_HIGH = 48,
    parameter int unsigned TX_LOW  = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] tx_count,
    input  logic             xfer_done,
    input  irq_vec_t         clr,
    input  logic             ien_wr,
    input  irq_vec_t         ien_wdata,
    output irq_vec_t         status,
    output irq_vec_t         enable,
    output logic             irq
);

    irq_vec_t cause;

    always_comb begin
        cause.rx_high   = (rx_count >= CNT_W'(RX_HIGH));
        cause.tx_low    = (tx_count <= CNT_W'(TX_LOW));
        cause.xfer_done = xfer_done;
    end

    // a present cause wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
        end else begin
            status <= irq_vec_t'((status & ~clr) | cause);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enable <= '0;
        end else if (ien_wr) begin
            enable <= ien_wdata;
        end
    end

    assign irq = |(status & enable);

    assert_rx_high_sets_R5: assert property (@(posedge clk) disable iff (rst)
        (rx_count >= CNT_W'(RX_HIGH)) |=> status.rx_high);

    assert_tx_low_sets_R6: assert property (@(posedge clk) disable iff (rst)
        (tx_count <= CNT_W'(TX_LOW)) |=> status.tx_low);

    assert_done_sets_R7: assert property (@(posedge clk) disable iff (rst)
        xfer_done |=> status.xfer_done);

    assert_done_w1c_R8: assert property (@(posedge clk) disable iff (rst)
        (clr.xfer_done && !xfer_done) |=> !status.xfer_done);

    assert_rx_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (status.rx_high && !clr.rx_high) |=> status.rx_high);

    assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (enable == '0) |-> !irq);

endmodule

// File: rtl/dfq_bus_regs.sv
module dfq_bus_regs
    import dfq_pkg::*;
#(
    parameter int unsigned CNT_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_cmd_t          cmd,
    input  logic [DATA_W-1:0] rx_head,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic [CNT_W-1:0]  tx_count,
    input  irq_vec_t          status,
    input  irq_vec_t          enable,
    output logic              rx_pop,
    output logic              tx_push,
    output logic [DATA_W-1:0] tx_wdata,
    output logic              tx_flush,
    output logic              rx_flush,
    output irq_vec_t          clr,
    output logic              ien_wr,
    output irq_vec_t          ien_wdata,
    output logic [WORD_W-1:0] rdata
);

    logic wr_ctrl;
    logic unused_wbits;

    assign wr_ctrl   = cmd.wr && (cmd.sel == SEL_CTRL);
    assign rx_pop    = cmd.rd && (cmd.sel == SEL_RXD);
    assign tx_push   = cmd.wr && (cmd.sel == SEL_TXD);
    assign tx_wdata  = cmd.wdata[DATA_W-1:0];
    assign ien_wr    = cmd.wr && (cmd.sel == SEL_IEN);
    assign ien_wdata = word_to_irq(cmd.wdata);
    assign clr       = (cmd.wr && (cmd.sel == SEL_ISTAT)) ? word_to_irq(cmd.wdata) : '0;
    assign unused_wbits = ^cmd.wdata;

    // flush bits live for exactly one cycle after their write
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_flush <= 1'b0;
            rx_flush <= 1'b0;
        end else begin
            tx_flush <= wr_ctrl && cmd.wdata[BIT_TX_FLUSH];
            rx_flush <= wr_ctrl && cmd.wdata[BIT_RX_FLUSH];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (cmd.rd) begin
            case (cmd.sel)
                SEL_RXD:   rdata <= WORD_W'(rx_head);
                SEL_CTRL: begin
                    rdata               <= '0;
                    rdata[BIT_TX_FLUSH] <= tx_flush;
                    rdata[BIT_RX_FLUSH] <= rx_flush;
                end
                SEL_IEN:   rdata <= irq_to_word(enable);
                SEL_ISTAT: rdata <= irq_to_word(status);
                SEL_FSTAT: rdata <= pack_fstat(FST_FIELD_W'(rx_count), FST_FIELD_W'(tx_count));
                default:   rdata <= '0;
            endcase
        end
    end

    // R4: reading an empty receive queue yields zero
    assert_empty_read_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (rx_pop && (rx_count == '0)) |=> (rdata == '0));

    // R10: a flush bit never stays up without a fresh write
    assert_flush_selfclear_R10: assert property (@(posedge clk) disable iff (rst)
        (tx_flush && !wr_ctrl) |=> !tx_flush);

endmodule

// File: rtl/dual_fifo_irq.sv
module dual_fifo_irq
    import dfq_pkg::*;
#(
    parameter int unsigned DEPTH = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    input  logic                eng_tx_pop,
    output logic [DATA_W-1:0]   eng_tx_data,
    output logic                eng_tx_empty,
    input  logic                eng_rx_push,
    input  logic [DATA_W-1:0]   eng_rx_data,
    output logic                eng_rx_full,
    input  logic                eng_done,
    output logic                irq
);

    localparam int unsigned CNT_W   = $clog2(DEPTH) + 1;
    localparam int unsigned RX_HIGH = (DEPTH * 3) / 4;
    localparam int unsigned TX_LOW  = DEPTH / 4;

    bus_cmd_t          cmd;
    logic              rx_pop;
    logic              tx_push;
    logic [DATA_W-1:0] tx_wdata;
    logic              tx_flush;
    logic              rx_flush;
    irq_vec_t          clr;
    logic              ien_wr;
    irq_vec_t          ien_wdata;
    irq_vec_t          status;
    irq_vec_t          enable;
    logic [DATA_W-1:0] rx_head;
    logic [CNT_W-1:0]  rx_count;
    logic [CNT_W-1:0]  tx_count;
    logic              tx_full;
    logic              rx_empty;
    logic              unused_flags;

    assign cmd.wr    = bus_wr;
    assign cmd.rd    = bus_rd;
    assign cmd.sel   = reg_sel_e'(bus_addr);
    assign cmd.wdata = bus_wdata;
    assign unused_flags = tx_full ^ rx_empty;

    dfq_byte_fifo #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_tx_fifo (
        .clk       (clk),
        .rst       (rst),
        .flush     (tx_flush),
        .push      (tx_push),
        .push_data (tx_wdata),
        .pop       (eng_tx_pop),
        .head      (eng_tx_data),
        .count     (tx_count),
        .full      (tx_full),
        .empty     (eng_tx_empty)
    );

    dfq_byte_fifo #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_rx_fifo (
        .clk       (clk),
        .rst       (rst),
        .flush     (rx_flush),
        .push      (eng_rx_push),
        .push_data (eng_rx_data),
        .pop       (rx_pop),
        .head      (rx_head),
        .count     (rx_count),
        .full      (eng_rx_full),
        .empty     (rx_empty)
    );

    dfq_bus_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .rx_head   (rx_head),
        .rx_count  (rx_count),
        .tx_count  (tx_count),
        .status    (status),
        .enable    (enable),
        .rx_pop    (rx_pop),
        .tx_push   (tx_push),
        .tx_wdata  (tx_wdata),
        .tx_flush  (tx_flush),
        .rx_flush  (rx_flush),
        .clr       (clr),
        .ien_wr    (ien_wr),
        .ien_wdata (ien_wdata),
        .rdata     (bus_rdata)
    );

    dfq_irq_unit #(.CNT_W(CNT_W), .RX_HIGH(RX_HIGH), .TX_LOW(TX_LOW)) u_irq (
        .clk       (clk),
        .rst       (rst),
        .rx_count  (rx_count),
        .tx_count  (tx_count),
        .xfer_done (eng_done),
        .clr       (clr),
        .ien_wr    (ien_wr),
        .ien_wdata (ien_wdata),
        .status    (status),
        .enable    (enable),
        .irq       (irq)
    );

    // R11: the engine never sees a byte while the queue reports empty
    assert_empty_head_zero_R11: assert property (@(posedge clk) disable iff (rst)
        eng_tx_empty |-> (eng_tx_data == '0));

endmodule

// File: tb/tb_dual_fifo_irq.sv
`timescale 1ns/1ps
module tb_dual_fifo_irq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        eng_tx_pop = 1'b0;
    logic [7:0]  eng_tx_data;
    logic        eng_tx_empty;
    logic        eng_rx_push = 1'b0;
    logic [7:0]  eng_rx_data = '0;
    logic        eng_rx_full;
    logic        eng_done = 1'b0;
    logic        irq;

    int n_total = 0;
    int n_bad   = 0;

    localparam logic [2:0] A_RXD = 3'd0, A_TXD = 3'd1, A_CTRL = 3'd2,
                           A_IEN = 3'd3, A_ISTAT = 3'd4, A_FSTAT = 3'd5;

    always #2 clk = ~clk;

    dual_fifo_irq dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data), .eng_tx_empty(eng_tx_empty),
        .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data), .eng_rx_full(eng_rx_full),
        .eng_done(eng_done), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic eng_push(input logic [7:0] d);
        eng_rx_data = d; eng_rx_push = 1'b1;
        @(negedge clk);
        eng_rx_push = 1'b0;
    endtask

    task automatic eng_pop(output logic [7:0] d);
        d = eng_tx_data; eng_tx_pop = 1'b1;
        @(negedge clk);
        eng_tx_pop = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] r;
        bus_read(A_FSTAT, r);  check("R3 reset occupancy", r, 32'h0);
        bus_read(A_CTRL, r);   check("R10 reset control", r, 32'h0);
        bus_read(A_ISTAT, r);  check("R6 reset status tx low", r, 32'h0000_1000);
        check("R9 reset irq", {31'b0, irq}, 32'h0);
        check("R11 reset tx empty", {31'b0, eng_tx_empty}, 32'h1);
    endtask

    task automatic t_order;
        logic [31:0] r;
        logic [7:0]  b;
        for (int i = 0; i < 5; i++) bus_write(A_TXD, 32'hA0 + i);
        bus_read(A_FSTAT, r); check("R3 tx occupancy field", r, 32'h0005_0000);
        check("R11 tx head", {24'b0, eng_tx_data}, 32'hA0);
        for (int i = 0; i < 5; i++) begin
            eng_pop(b); check("R2 tx order", {24'b0, b}, 32'hA0 + i);
        end
        check("R11 tx empty after drain", {31'b0, eng_tx_empty}, 32'h1);
        for (int i = 0; i < 3; i++) eng_push(8'h51 + 8'(i * 7));
        bus_read(A_FSTAT, r); check("R3 rx occupancy field", r, 32'h0000_0003);
        for (int i = 0; i < 3; i++) begin
            bus_read(A_RXD, r); check("R2 rx order", r, 32'h51 + i * 7);
        end
    endtask

    task automatic t_empty;
        logic [31:0] r;
        logic [7:0]  b;
        bus_read(A_RXD, r);   check("R4 empty rx read zero", r, 32'h0);
        eng_pop(b);           check("R4 empty tx head zero", {24'b0, b}, 32'h0);
        bus_read(A_FSTAT, r); check("R4 occupancy stays zero", r, 32'h0);
    endtask

    task automatic t_full;
        logic [31:0] r;
        logic [7:0]  b;
        for (int i = 0; i < 65; i++) bus_write(A_TXD, 32'(i));
        for (int i = 0; i < 65; i++) eng_push(8'(255 - i));
        bus_read(A_FSTAT, r); check("R1 both full at 64", r, 32'h0040_0040);
        check("R1 rx full flag", {31'b0, eng_rx_full}, 32'h1);
        for (int i = 0; i < 64; i++) begin
            eng_pop(b); check("R1 tx order after overfill", {24'b0, b}, 32'(i));
        end
        check("R11 tx empty after 64 pops", {31'b0, eng_tx_empty}, 32'h1);
    endtask

    task automatic t_flush;
        logic [31:0] r;
        bus_write(A_CTRL, 32'h0000_0200);
        bus_read(A_CTRL, r);  check("R10 rx flush bit visible one cycle", r, 32'h0000_0200);
        bus_read(A_CTRL, r);  check("R10 rx flush bit self clears", r, 32'h0);
        bus_read(A_FSTAT, r); check("R10 rx flushed", r, 32'h0);
        for (int i = 0; i < 3; i++) bus_write(A_TXD, 32'h77);
        bus_write(A_CTRL, 32'h0000_0100);
        idle(1);
        bus_read(A_FSTAT, r); check("R10 tx flushed", r, 32'h0);
        bus_read(A_CTRL, r);  check("R10 tx flush bit self clears", r, 32'h0);
    endtask

    task automatic t_rx_thr;
        logic [31:0] r;
        bus_write(A_ISTAT, 32'hFFFF_FFFF);
        for (int i = 0; i < 47; i++) eng_push(8'(i));
        idle(2);
        bus_read(A_ISTAT, r); check("R5 below threshold", r & 32'h10, 32'h0);
        eng_push(8'h2F);
        idle(2);
        bus_read(A_ISTAT, r); check("R5 at 48 sets", r & 32'h10, 32'h10);
        bus_write(A_ISTAT, 32'h10); idle(2);
        bus_read(A_ISTAT, r); check("R8 clear refused while high", r & 32'h10, 32'h10);
        bus_read(A_RXD, r);
        bus_write(A_ISTAT, 32'h10); idle(2);
        bus_read(A_ISTAT, r); check("R8 clear after service", r & 32'h10, 32'h0);
        bus_write(A_CTRL, 32'h200); idle(1);
    endtask

    task automatic t_tx_thr;
        logic [31:0] r;
        logic [7:0]  b;
        bus_write(A_ISTAT, 32'h1000); idle(1);
        bus_read(A_ISTAT, r); check("R8 tx low re-sets while empty", r & 32'h1000, 32'h1000);
        for (int i = 0; i < 17; i++) bus_write(A_TXD, 32'(i));
        bus_write(A_ISTAT, 32'h1000); idle(2);
        bus_read(A_ISTAT, r); check("R6 at 17 clear holds", r & 32'h1000, 32'h0);
        eng_pop(b); idle(2);
        bus_read(A_ISTAT, r); check("R6 at 16 sets", r & 32'h1000, 32'h1000);
        bus_write(A_CTRL, 32'h100); idle(1);
    endtask

    task automatic t_done;
        logic [31:0] r;
        bus_write(A_ISTAT, 32'hFFFF_FFFF); idle(1);
        bus_read(A_ISTAT, r); check("R8 all ones clear", r & 32'h10010, 32'h0);
        eng_done = 1'b1; @(negedge clk); eng_done = 1'b0;
        idle(2);
        bus_read(A_ISTAT, r); check("R7 done sets", r & 32'h10000, 32'h10000);
        bus_write(A_ISTAT, 32'h0); idle(1);
        bus_read(A_ISTAT, r); check("R8 zero write keeps", r & 32'h10000, 32'h10000);
        bus_write(A_ISTAT, 32'h10000); idle(1);
        bus_read(A_ISTAT, r); check("R8 done cleared", r & 32'h10000, 32'h0);
    endtask

    task automatic t_irq;
        logic [31:0] r;
        bus_write(A_IEN, 32'hFFFF_FFFF);
        bus_read(A_IEN, r); check("R9 enable readback", r, 32'h0001_1010);
        bus_write(A_IEN, 32'h0);
        eng_done = 1'b1; @(negedge clk); eng_done = 1'b0;
        idle(2);
        check("R9 masked irq low", {31'b0, irq}, 32'h0);
        bus_write(A_IEN, 32'h10000); idle(1);
        check("R9 done enabled irq high", {31'b0, irq}, 32'h1);
        bus_write(A_ISTAT, 32'h10000); idle(1);
        check("R9 irq low after clear", {31'b0, irq}, 32'h0);
        bus_write(A_IEN, 32'h1000); idle(1);
        check("R9 tx low enabled irq high", {31'b0, irq}, 32'h1);
        bus_write(A_IEN, 32'h0); idle(1);
        check("R9 irq low when disabled", {31'b0, irq}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle(2);
        t_reset();
        t_order();
        t_empty();
        t_full();
        t_flush();
        t_rx_thr();
        t_tx_thr();
        t_done();
        t_irq();
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_total++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

endmodule